// File: doc/BRIEF.md
# Double-Buffered Delay Trigger Generator

This block produces a fixed set of delayed trigger pulses in every control cycle. A control cycle begins with a master reload. The reload can come from a hardware strobe, or from a request bit that software sets through the write port. At the reload, the generator copies every shadow setting into its active copy. These settings are eight compare values, the counter start value, a stop value and a prescale divider. The counter is loaded with the start value.

The comparators stay blind for one cycle after the reload. The counter then advances once per prescale period. Each of the eight comparators emits a one-cycle pulse the first time the counter equals its value. A separate stop comparator freezes the counter when it reaches the stop value, so no later trigger can fire before the next reload.

Software writes only the shadow copies. A write made while a cycle is running therefore shapes the next control cycle and leaves the current one unchanged. The reload pulse is driven out next to the trigger vector, so a downstream scheduler can align on it.

The controller has four states:
- `ST_IDLE`: the block is disabled or has not yet been reloaded.
- `ST_BLIND`: the one cycle after a reload, with the comparators disabled.
- `ST_RUN`: the counter is counting and the comparators are armed.
- `ST_HALT`: the counter is frozen at the stop value.

The transitions are:
- any state → `ST_BLIND` on a reload.
- any state → `ST_IDLE` when `enable` is low.
- `ST_BLIND` → `ST_RUN` after one cycle.
- `ST_RUN` → `ST_HALT` when the counter equals the stop value.
- `ST_IDLE` and `ST_HALT` otherwise hold.

Top module: `reload_trigger_gen`

## Requirements
- R1: `reload_o` is high in exactly those cycles where `enable` is high and either `hw_reload` is high or a software request is pending.
- R2: A write to address 11 with data bit 0 set makes a software request pending from the next cycle. Any reload clears the request, so one request yields a single `reload_o` pulse. A request written in the same cycle as a reload is dropped.
- R3: Writes go to shadow copies at these addresses: compare i at address i (0..7), start value at 8, stop value at 9, and prescale select at 10 (data bits 1:0). The active copies change only at a reload. A write made during a running cycle does not alter that cycle's triggers.
- R4: No trigger fires in the reload cycle or in the cycle that follows it.
- R5: Let t be the reload cycle. In cycle t+2 the counter holds the start value. It then increments by one (modulo 2^8) every d cycles, where d = prescale select + 1 (1 to 4). In cycle t+2+j it therefore equals start + floor(j/d).
- R6: `trig_o[i]` is a one-cycle pulse in the first cycle after t+1 where the counter equals compare i, and fires at most once per control cycle.
- R7: The counter freezes once it equals the stop value. A compare equal to the stop value still fires. A compare that lies further from the start value than the stop value (modulo 2^8) never fires.
- R8: While `enable` is low, no reload is produced and no trigger fires.
- R9: After reset, `reload_o` and `trig_o` are low, all shadow values are zero and the prescaler divides by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low suppresses reloads and triggers |
| hw_reload | input | 1 | Hardware master reload strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Write address (0..11) |
| wr_data | input | CNT_W (8) | Write data |
| trig_o | output | N_TRIG (8) | Delayed trigger pulses |
| reload_o | output | 1 | Master reload pulse |

## Verification
The main sweep crosses all four prescale settings with three start values. One of the start values makes the compares wrap past zero. Each run uses compares at offsets 0, 1, 2, 3, 5, 6, 7 and −1 from the start value, with the stop value at offset 6. This shows the exact firing cycle for every divider, that an equal-to-stop compare still fires, and that compares beyond the stop never fire.

Runs alternate between hardware and software reload, which separates the two reload paths and the clearing of the request. Every run rewrites all shadow registers with junk while it is still going. This tells apart a correct shadow/active split from one where writes leak straight into the active copies. A final phase holds `enable` low while strobing the reload input.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLIND = 2'd1,
        ST_RUN   = 2'd2,
        ST_HALT  = 2'd3
    } dtg_state_e;
endpackage

// File: rtl/dtg_shadow_bank.sv
module dtg_shadow_bank #(
    parameter int N_TRIG = 8,
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 2,
    parameter int ADDR_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [CNT_W-1:0]                 wr_data,
    input  logic                             reload_take,
    output logic [N_TRIG-1:0][CNT_W-1:0]     cmp_sh,
    output logic [CNT_W-1:0]                 init_sh,
    output logic [CNT_W-1:0]                 stop_sh,
    output logic [PRE_W-1:0]                 presc_sh,
    output logic                             sw_req
);
    localparam logic [ADDR_W-1:0] A_INIT  = ADDR_W'(N_TRIG);
    localparam logic [ADDR_W-1:0] A_STOP  = ADDR_W'(N_TRIG + 1);
    localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(N_TRIG + 2);
    localparam logic [ADDR_W-1:0] A_SWREQ = ADDR_W'(N_TRIG + 3);

    for (genvar i = 0; i < N_TRIG; i++) begin : g_cmp_sh
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cmp_sh[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
                cmp_sh[i] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_sh  <= '0;
            stop_sh  <= '0;
            presc_sh <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_INIT)  init_sh  <= wr_data;
            if (wr_addr == A_STOP)  stop_sh  <= wr_data;
            if (wr_addr == A_PRESC) presc_sh <= wr_data[PRE_W-1:0];
        end
    end

    // Request bit: a reload always wins over a concurrent set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sw_req <= 1'b0;
        else if (reload_take)
            sw_req <= 1'b0;
        else if (wr_en && wr_addr == A_SWREQ && wr_data[0])
            sw_req <= 1'b1;
    end
endmodule

// File: rtl/dtg_prescaler.sv
module dtg_prescaler #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [PRE_W-1:0] div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt_q;

    assign tick = run && (pcnt_q == div_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (clear)
            pcnt_q <= '0;
        else if (run)
            pcnt_q <= (pcnt_q == div_sel) ? '0 : pcnt_q + 1'b1;
    end
endmodule

// File: rtl/dtg_comparator.sv
module dtg_comparator #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] count,
    input  logic             armed,
    output logic             trig
);
    logic [CNT_W-1:0] act_q;
    logic             fired_q;

    assign trig = armed && !fired_q && (count == act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= '0;
            fired_q <= 1'b0;
        end else if (reload) begin
            act_q   <= load_val;
            fired_q <= 1'b0;
        end else if (trig) begin
            fired_q <= 1'b1;
        end
    end
endmodule

// File: rtl/reload_trigger_gen.sv
module reload_trigger_gen
    import dtg_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hw_reload,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [N_TRIG-1:0] trig_o,
    output logic              reload_o
);
    logic [N_TRIG-1:0][CNT_W-1:0] cmp_sh;
    logic [CNT_W-1:0]             init_sh;
    logic [CNT_W-1:0]             stop_sh;
    logic [PRE_W-1:0]             presc_sh;
    logic                         sw_req;

    dtg_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] stop_act_q;
    logic [PRE_W-1:0] presc_act_q;
    logic             reload;
    logic             stop_hit;
    logic             armed;
    logic             pre_run;
    logic             tick;

    assign reload   = enable && (hw_reload || sw_req);
    assign reload_o = reload;

    dtg_shadow_bank #(
        .N_TRIG(N_TRIG), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)
    ) shadow_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .reload_take(reload), .cmp_sh(cmp_sh),
        .init_sh(init_sh), .stop_sh(stop_sh), .presc_sh(presc_sh),
        .sw_req(sw_req)
    );

    // Next-state process
    always_comb begin
        state_d = state_q;
        if (!enable)
            state_d = ST_IDLE;
        else if (reload)
            state_d = ST_BLIND;
        else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BLIND: state_d = ST_RUN;
                ST_RUN:   state_d = stop_hit ? ST_HALT : ST_RUN;
                ST_HALT:  state_d = ST_HALT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output / datapath control decode
    always_comb begin
        stop_hit = (count_q == stop_act_q);
        armed    = 1'b0;
        pre_run  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BLIND: ;
            ST_RUN: begin
                armed   = enable && !reload;
                pre_run = enable && !reload && !stop_hit;
            end
            ST_HALT:  ;
        endcase
    end

    dtg_prescaler #(.PRE_W(PRE_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .clear(reload), .run(pre_run),
        .div_sel(presc_act_q), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q     <= '0;
            stop_act_q  <= '0;
            presc_act_q <= '0;
        end else if (reload) begin
            count_q     <= init_sh;
            stop_act_q  <= stop_sh;
            presc_act_q <= presc_sh;
        end else if (tick) begin
            count_q     <= count_q + 1'b1;
        end
    end

    for (genvar i = 0; i < N_TRIG; i++) begin : g_cmp
        dtg_comparator #(.CNT_W(CNT_W)) cmp_i (
            .clk(clk), .rst_n(rst_n), .reload(reload),
            .load_val(cmp_sh[i]), .count(count_q), .armed(armed),
            .trig(trig_o[i])
        );
    end
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              reload_o,
    input logic [N_TRIG-1:0] trig_o,
    input logic              sw_req,
    input dtg_state_e        state,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  init_sh
);
    a_r4_blind_reload: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |-> (trig_o == '0));

    a_r4_blind_next: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reload_o) |-> (trig_o == '0));

    a_r2_request_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> !sw_req);

    a_r5_start_value: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> (count == $past(init_sh)));

    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !reload_o) |=>
            (count == $past(count) || count == $past(count) + 1'b1));

    a_r7_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !reload_o) |=> $stable(count));

    a_r7_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (trig_o == '0));

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!reload_o && trig_o == '0));
endmodule

bind reload_trigger_gen dtg_checker #(.N_TRIG(N_TRIG), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .reload_o(reload_o),
    .trig_o(trig_o), .sw_req(sw_req), .state(state_q), .count(count_q),
    .init_sh(init_sh)
);

// File: tb/reload_trigger_gen_tb.sv
module reload_trigger_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 32;
    localparam int STOP_OFS   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       hw_reload = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] trig_o;
    logic       reload_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    reload_trigger_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hw_reload(hw_reload),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_o(trig_o), .reload_o(reload_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One control cycle: program shadows, reload, watch WIN cycles.
    task automatic do_run(input logic [7:0] init, input int d, input bit use_sw);
        logic [7:0] ofs [8] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5, 8'd6, 8'd7, 8'd255};
        int first_k [8];
        int nfire [8];
        for (int i = 0; i < 8; i++) begin
            wr(4'(i), init + ofs[i]);
            first_k[i] = -1;
            nfire[i] = 0;
        end
        wr(4'd8, init);
        wr(4'd9, init + 8'(STOP_OFS));
        wr(4'd10, 8'(d - 1));
        if (use_sw) begin
            wr_en = 1'b1; wr_addr = 4'd11; wr_data = 8'd1;
        end
        // cycle k = 0 : reload cycle
        @(negedge clk);
        wr_en = 1'b0;
        hw_reload = !use_sw;
        #1;
        check(reload_o == 1'b1, use_sw ? "R2 sw reload" : "R1 hw reload", reload_o, 1);
        check(trig_o == 8'h00, "R4 reload cycle silent", trig_o, 0);
        for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            hw_reload = 1'b0;
            // R3: junk into every shadow while running
            if (k >= 3 && k <= 13) begin
                wr_en = 1'b1; wr_addr = 4'(k - 3); wr_data = 8'hEE;
            end else begin
                wr_en = 1'b0;
            end
            #1;
            if (k == 1) begin
                check(reload_o == 1'b0, "R2 single reload pulse", reload_o, 0);
                check(trig_o == 8'h00, "R4 blind cycle silent", trig_o, 0);
            end
            for (int i = 0; i < 8; i++)
                if (trig_o[i]) begin
                    nfire[i]++;
                    if (first_k[i] < 0) first_k[i] = k;
                end
        end
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            int dv = int'(ofs[i]);
            int ek = (dv <= STOP_OFS) ? 2 + dv * d : -1;
            if (ek < 0)
                check(nfire[i] == 0, "R7 beyond-stop compare silent", nfire[i], 0);
            else
                check(nfire[i] == 1 && first_k[i] == ek,
                      "R6/R5/R3 trigger cycle", first_k[i] * 100 + nfire[i],
                      ek * 100 + 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(reload_o == 1'b0, "R9 reset reload low", reload_o, 0);
        check(trig_o == 8'h00, "R9 reset triggers low", trig_o, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        for (int d = 1; d <= 4; d++) begin
            do_run(8'd0,   d, 1'b0);
            do_run(8'd3,   d, 1'b1);
            do_run(8'd250, d, (d % 2) == 0);
        end
        // R8: disabled block ignores reload strobes
        @(negedge clk);
        enable = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            hw_reload = 1'b1;
            #1;
            check(reload_o == 1'b0 && trig_o == 8'h00, "R8 disabled quiet",
                  {reload_o, trig_o}, 0);
        end
        @(negedge clk);
        hw_reload = 1'b0;
        enable = 1'b1;
        #1;
        check(reload_o == 1'b0, "R1 no reload without source", reload_o, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule